// File: doc/BRIEF.md
# Hall-Sensor Commutation Controller with Direction Control

This block turns the three Hall-effect position signals of a 3-phase brushless DC motor into six gate enables, one high-side and one low-side per phase, using 120° block commutation. Each Hall input is brought into the clock domain by two flops. It then passes a lockout filter, which accepts a level change and then ignores that input for a fixed number of cycles. This keeps switching noise from causing false commutation. The filtered Hall pattern and the active direction select one of six bridge states. In each state, one phase's high side carries the PWM duty signal and another phase's low side is held on.

A requested direction change is not applied while the rotor is turning. Until the rotor is judged stopped, the gates are released so the motor coasts. The rotor counts as stopped once the interval since the last filtered U edge reaches a parameterised limit. A saturating counter measures that interval, so a rotor that never moves also counts as stopped. Braking turns on all low sides. The two Hall patterns that are impossible in operation, all-high and all-low, release the bridge and raise a flag. A speed output mirrors the filtered U signal.

Top module: `hall_commutator`

## Requirements
- R1: After a Hall input's filtered value takes a new level, that input's filtered value holds for LOCKOUT_CYC cycles regardless of the raw input. A change of the raw input reaches the filtered value on the third rising clock edge, provided no lockout is running.
- R2: The Hall pattern is written as {U,V,W}, with 1 meaning high. With the active direction at 1, patterns 001, 011, 010, 110, 100 and 101 select states 1 to 6. With the active direction at 0, states 1 to 6 are selected by the bitwise complements 110, 100, 101, 001, 011 and 010.
- R3: Each state has one PWM-driven high side and one low side held on. State 1 uses high side V and low side W. State 2 uses U and W. State 3 uses U and V. State 4 uses W and V. State 5 uses W and U. State 6 uses V and U. The selected high side equals the PWM input and every other gate is off.
- R4: When synchronous rectification is enabled, the low side of the PWM-driven phase equals the inverted PWM input. When it is disabled, that low side stays off. A phase never has its high and low gates on together.
- R5: The applied direction changes only when the direction input differs from it and the filtered U signal has had no edge for STOP_CYC cycles. While the input and the applied direction differ, all six gates are off.
- R6: While enabled and braking, all three low sides are on and all high sides are off. This holds whatever the Hall pattern or direction state.
- R7: The invalid flag is high exactly when the filtered pattern is 000 or 111. Without braking, an invalid pattern turns all six gates off.
- R8: The speed output equals the filtered U signal.
- R9: With the enable low, all six gate outputs are low. The enable takes priority over braking, and braking takes priority over the invalid and coast conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_u_i | input | 1 | Raw Hall U level |
| hall_v_i | input | 1 | Raw Hall V level |
| hall_w_i | input | 1 | Raw Hall W level |
| dir_i | input | 1 | Requested direction |
| brake_i | input | 1 | Brake request, active high |
| pwm_i | input | 1 | Duty-cycle signal for the driven high side |
| en_i | input | 1 | Drive enable, active high |
| sync_en_i | input | 1 | Synchronous rectification enable |
| u_hi_o | output | 1 | Phase U high-side gate enable |
| u_lo_o | output | 1 | Phase U low-side gate enable |
| v_hi_o | output | 1 | Phase V high-side gate enable |
| v_lo_o | output | 1 | Phase V low-side gate enable |
| w_hi_o | output | 1 | Phase W high-side gate enable |
| w_lo_o | output | 1 | Phase W low-side gate enable |
| hallout_o | output | 1 | Speed output, the filtered Hall U |
| invalid_o | output | 1 | Filtered Hall pattern is all-high or all-low |

## Verification
The bench builds the block with LOCKOUT_CYC set to 6 and STOP_CYC set to 60 in place of the microsecond and millisecond defaults. With these values a glitch can be placed inside the lockout window and another outside it. A Hall step of 12 cycles makes the U edges arrive faster than the stop limit, while a 40-cycle step makes them arrive slower. This lets the test cover a reversal requested at speed, one requested while slow, and the idle wait that lets the new direction take effect, all within a few thousand cycles.

// File: rtl/hall_commutator.sv
module hall_commutator #(
  parameter int LOCKOUT_CYC = 1000,
  parameter int STOP_CYC    = 8_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hall_u_i,
  input  logic hall_v_i,
  input  logic hall_w_i,
  input  logic dir_i,
  input  logic brake_i,
  input  logic pwm_i,
  input  logic en_i,
  input  logic sync_en_i,
  output logic u_hi_o,
  output logic u_lo_o,
  output logic v_hi_o,
  output logic v_lo_o,
  output logic w_hi_o,
  output logic w_lo_o,
  output logic hallout_o,
  output logic invalid_o
);

  localparam int LW = $clog2(LOCKOUT_CYC + 1);
  localparam int PW = $clog2(STOP_CYC + 1);

  // bit 2 = U, bit 1 = V, bit 0 = W
  logic [2:0] raw, sy1, sy2, filt, acc;
  logic [PW-1:0] per_cnt;
  logic dir_act, stopped, coast;
  logic [2:0] pat, hs, ls, hi, lo;

  assign raw = {hall_u_i, hall_v_i, hall_w_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
    end else begin
      sy1 <= raw;
      sy2 <= sy1;
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_flt
    logic [LW-1:0] cnt;
    logic f_q;
    assign acc[i]  = (cnt == '0) && (sy2[i] != f_q);
    assign filt[i] = f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0;
        f_q <= 1'b0;
      end else if (cnt != '0) begin
        cnt <= cnt - LW'(1);
      end else if (acc[i]) begin
        f_q <= sy2[i];
        cnt <= LW'(LOCKOUT_CYC);
      end
    end
  end

  assign stopped = (per_cnt == PW'(STOP_CYC));
  assign coast   = (dir_i != dir_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt <= PW'(STOP_CYC);
      dir_act <= 1'b1;
    end else begin
      if (acc[2])        per_cnt <= '0;
      else if (!stopped) per_cnt <= per_cnt + PW'(1);
      if (coast && stopped) dir_act <= dir_i;
    end
  end

  assign invalid_o = (filt == 3'b000) || (filt == 3'b111);
  assign hallout_o = filt[2];
  assign pat       = dir_act ? filt : ~filt;

  always_comb begin
    hs = 3'b000;
    ls = 3'b000;
    case (pat)
      3'b001: begin hs = 3'b010; ls = 3'b001; end
      3'b011: begin hs = 3'b100; ls = 3'b001; end
      3'b010: begin hs = 3'b100; ls = 3'b010; end
      3'b110: begin hs = 3'b001; ls = 3'b010; end
      3'b100: begin hs = 3'b001; ls = 3'b100; end
      3'b101: begin hs = 3'b010; ls = 3'b100; end
      default: ;
    endcase
  end

  always_comb begin
    hi = 3'b000;
    lo = 3'b000;
    if (!en_i) begin
      hi = 3'b000;
    end else if (brake_i) begin
      lo = 3'b111;
    end else if (!invalid_o && !coast) begin
      hi = hs & {3{pwm_i}};
      lo = ls | (hs & {3{sync_en_i & ~pwm_i}});
    end
  end

  assign {u_hi_o, v_hi_o, w_hi_o} = hi;
  assign {u_lo_o, v_lo_o, w_lo_o} = lo;

endmodule

// File: rtl/hall_commutator_chk.sv
module hall_commutator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic       brake_i,
  input logic       pwm_i,
  input logic       sync_en_i,
  input logic       hallout_o,
  input logic       invalid_o,
  input logic [2:0] hi,
  input logic [2:0] lo
);

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (hi & lo) == 3'b000); // R4

  AST_SYNC_OFF_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !brake_i && !sync_en_i) |-> $countones(lo) <= 1); // R4

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (hi == 3'b000 && lo == 3'b000)); // R9

  AST_BRAKE_LOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && brake_i) |-> (hi == 3'b000 && lo == 3'b111)); // R6

  AST_INVALID_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !brake_i && invalid_o) |-> (hi == 3'b000 && lo == 3'b000)); // R7

  AST_HIGH_ONLY_ON_PWM: assert property (@(posedge clk) disable iff (!rst_n)
    (hi != 3'b000) |-> (pwm_i && $onehot0(hi))); // R3

  AST_LOCKOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hallout_o != $past(hallout_o)) |=> $stable(hallout_o)); // R1

endmodule

bind hall_commutator hall_commutator_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_i      (en_i),
  .brake_i   (brake_i),
  .pwm_i     (pwm_i),
  .sync_en_i (sync_en_i),
  .hallout_o (hallout_o),
  .invalid_o (invalid_o),
  .hi        ({u_hi_o, v_hi_o, w_hi_o}),
  .lo        ({u_lo_o, v_lo_o, w_lo_o})
);

// File: tb/hall_commutator_tb.sv
`timescale 1ns/1ps
module hall_commutator_tb;

  localparam int L = 6;
  localparam int S = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hu = 0, hv = 0, hw = 0;
  logic dir = 1, brake = 0, pwm = 0, en = 0, sync_en = 0;
  logic u_hi, u_lo, v_hi, v_lo, w_hi, w_lo, hallout, invalid;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hall_commutator #(.LOCKOUT_CYC(L), .STOP_CYC(S)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .hall_u_i(hu), .hall_v_i(hv), .hall_w_i(hw),
    .dir_i(dir), .brake_i(brake), .pwm_i(pwm), .en_i(en), .sync_en_i(sync_en),
    .u_hi_o(u_hi), .u_lo_o(u_lo), .v_hi_o(v_hi), .v_lo_o(v_lo),
    .w_hi_o(w_hi), .w_lo_o(w_lo), .hallout_o(hallout), .invalid_o(invalid)
  );

  // reference model, index 0 = U, 1 = V, 2 = W
  int ms1[3], ms2[3], mf[3], mc[3];
  int mper, mdir;
  bit mready = 0;

  always @(posedge clk) begin
    int raw[3];
    bit ue;
    int p, q, hsi, lsi;
    int eh[3], el[3];
    string tag;
    logic [5:0] got, exp_v;
    raw[0] = hu; raw[1] = hv; raw[2] = hw;
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin ms1[i] = 0; ms2[i] = 0; mf[i] = 0; mc[i] = 0; end
      mper = S; mdir = 1; mready = 1;
    end else begin
      ue = 0;
      if (dir != mdir && mper == S) mdir = dir;
      for (int i = 0; i < 3; i++) begin
        if (mc[i] > 0) mc[i]--;
        else if (ms2[i] != mf[i]) begin
          mf[i] = ms2[i]; mc[i] = L;
          if (i == 0) ue = 1;
        end
      end
      if (ue) mper = 0;
      else if (mper < S) mper++;
      for (int i = 0; i < 3; i++) begin ms2[i] = ms1[i]; ms1[i] = raw[i]; end
    end
    #5;
    if (mready && !done) begin
      p = mf[0]*4 + mf[1]*2 + mf[2];
      q = (mdir == 1) ? p : 7 - p;
      case (q)
        1: begin hsi = 1; lsi = 2; end
        3: begin hsi = 0; lsi = 2; end
        2: begin hsi = 0; lsi = 1; end
        6: begin hsi = 2; lsi = 1; end
        4: begin hsi = 2; lsi = 0; end
        5: begin hsi = 1; lsi = 0; end
        default: begin hsi = -1; lsi = -1; end
      endcase
      for (int i = 0; i < 3; i++) begin eh[i] = 0; el[i] = 0; end
      if (!en) tag = "R9";
      else if (brake) begin
        tag = "R6";
        for (int i = 0; i < 3; i++) el[i] = 1;
      end else if (p == 0 || p == 7) tag = "R7";
      else if (dir != mdir) tag = "R5";
      else begin
        tag = "R1 R2 R3 R4";
        eh[hsi] = pwm;
        el[lsi] = 1;
        if (sync_en && !pwm) el[hsi] = 1;
      end
      got   = {u_hi, u_lo, v_hi, v_lo, w_hi, w_lo};
      exp_v = {eh[0][0], el[0][0], eh[1][0], el[1][0], eh[2][0], el[2][0]};
      compared++;
      if (got !== exp_v) begin
        mismatched++;
        $display("FAIL %s gates at %0t: got %b expected %b", tag, $time, got, exp_v);
      end
      compared++;
      if (hallout !== mf[0][0]) begin
        mismatched++;
        $display("FAIL R8 speed output at %0t: got %b expected %0d", $time, hallout, mf[0]);
      end
      compared++;
      if (invalid !== ((p == 0 || p == 7) ? 1'b1 : 1'b0)) begin
        mismatched++;
        $display("FAIL R7 invalid flag at %0t: got %b expected %0d", $time, invalid, (p == 0 || p == 7));
      end
    end
  end

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      pwm = ~pwm;
    end
  end

  task automatic hstep(input logic [2:0] pat, input int n);
    hu = pat[2]; hv = pat[1]; hw = pat[0];
    repeat (n) @(negedge clk);
  endtask

  task automatic spin_fwd(input int n);
    hstep(3'b001, n); hstep(3'b011, n); hstep(3'b010, n);
    hstep(3'b110, n); hstep(3'b100, n); hstep(3'b101, n);
  endtask

  task automatic spin_rev(input int n);
    hstep(3'b110, n); hstep(3'b100, n); hstep(3'b101, n);
    hstep(3'b001, n); hstep(3'b011, n); hstep(3'b010, n);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R9: disabled while Hall moves
    spin_fwd(12);
    en = 1;
    // R2 R3: forward drive, no rectification, then with it (R4)
    spin_fwd(12); spin_fwd(12);
    sync_en = 1;
    spin_fwd(12);
    // R1: glitch inside lockout, then a glitch outside it
    hstep(3'b011, 4); hstep(3'b001, 2); hstep(3'b011, 12);
    hstep(3'b010, 2); hstep(3'b011, 14);
    // R5: reversal at speed coasts, idle lets it apply
    hstep(3'b010, 12); hstep(3'b110, 5);
    dir = 0;
    hstep(3'b110, 7); hstep(3'b100, 12); hstep(3'b101, 12);
    hstep(3'b101, 80);
    spin_rev(12); spin_rev(12);
    sync_en = 0;
    spin_rev(12);
    // R5: slow rotation reversal
    spin_rev(40);
    dir = 1;
    spin_fwd(40); spin_fwd(12);
    // R6: brake over rotation and over an invalid pattern
    brake = 1;
    spin_fwd(12);
    hstep(3'b000, 12);
    brake = 0;
    // R7: invalid patterns
    hstep(3'b000, 15); hstep(3'b111, 15);
    spin_fwd(12);
    // R9: enable dropped mid-rotation, with brake also requested
    en = 0;
    hstep(3'b001, 12); brake = 1; hstep(3'b011, 12); brake = 0;
    en = 1;
    spin_fwd(12);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule